// File: doc/BRIEF.md
# Auto-Masking Priority Interrupt Controller

This block gathers a parameterised set of level-sensitive hardware interrupt lines into one CPU interrupt output. Every line has a mask bit and a software-trigger bit. A line requests service while its hardware input is high or its software-trigger bit is set. A request reaches the CPU only while the line is unmasked. Among the unmasked requesting lines, the one with the smallest index always wins.

Software takes an event by reading a dedicated event port, which is separate from the main register bus. The read returns the winning line and sets that line's mask bit on the same clock edge. A line therefore never has to be acknowledged by a separate write, and it stays silent until software unmasks it again. Masks and software triggers are changed through write-one-to-set and write-one-to-clear words, 32 lines per bank, on a simple register bus. Every read, on either port, returns its data exactly one cycle later.

Top module: `irq_prio_ctrl`

## Requirements
- R1: After reset every line is masked, every software-trigger bit is clear, `irq_out` is low and neither read-valid output is high.
- R2: A line requests while `hw_irq[i]` is high or its software-trigger bit is set. `irq_out` is high exactly when some requesting line is unmasked. A masked line never raises `irq_out`.
- R3: A bus write with group field `addr[9:8]`=0 sets the mask bits of bank `addr[7:2]` wherever the data has a one. Group 1 clears them the same way. A read of group 0 or 1 returns that bank's 32 mask bits, line 32*bank+k in bit k.
- R4: Group 2 sets and group 3 clears the software-trigger bits of bank `addr[7:2]` wherever the data has a one. A read of group 2 or 3 returns the bank's software-trigger bits.
- R5: An event read reports the lowest-index line that is both requesting and unmasked. The word has 0x0001 in bits [31:16] and the line number in bits [15:0].
- R6: An event read that reports a line also sets that line's mask bit on the same edge. If no other unmasked line is requesting, `irq_out` is low in the following cycle.
- R7: An event read with no unmasked request returns 0x00000000 and leaves every mask bit unchanged.
- R8: An event read and a bus mask-clear write for the reported line can fall on the same edge. In that case the line ends up masked.
- R9: A line whose hardware input is still high requests again as soon as it is unmasked, and it is reported again by the next event read.
- R10: `bus_rvalid` is high for exactly the cycle after a bus read request. `evt_rvalid` is high for exactly the cycle after `evt_rd`. Data is valid in that cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| hw_irq | input | NUM_LINES | Level-sensitive hardware interrupt lines |
| bus_req | input | 1 | Register bus access strobe |
| bus_we | input | 1 | 1 = write, 0 = read |
| bus_addr | input | ADDR_W | Byte address: [9:8] group, [7:2] bank, [1:0] must be 0 |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, valid with bus_rvalid |
| bus_rvalid | output | 1 | Read data valid, one cycle after the request |
| evt_rd | input | 1 | Event read strobe |
| evt_rdata | output | 32 | Event word, valid with evt_rvalid |
| evt_rvalid | output | 1 | Event data valid, one cycle after evt_rd |
| irq_out | output | 1 | CPU interrupt request |

## Verification
Register and event read data is due in the single cycle after the request edge. Mask and software-trigger updates, including the automatic mask from an event read, take effect on that same request edge, so `irq_out` reflects them from the cycle after. The bench drives its inputs on falling edges and queues each expected read word before the request edge. A monitor compares the data at the next falling edge. One falling edge after that, the bench confirms that the queue has drained, which catches both late and missing responses. `irq_out` is compared at falling edges against a model of masks, triggers and inputs that the bench keeps on its own.

// File: rtl/irq_ctrl_pkg.sv
package irq_ctrl_pkg;

  localparam int WORD_W = 32;
  localparam int BANK_FW = 6;
  localparam logic [15:0] EVT_KIND_HW = 16'h0001;

  typedef enum logic [1:0] {
    GRP_MASK_SET = 2'd0,
    GRP_MASK_CLR = 2'd1,
    GRP_TRIG_SET = 2'd2,
    GRP_TRIG_CLR = 2'd3
  } reg_grp_e;

  // Event word: kind in the upper half, line number in the lower half.
  function automatic logic [WORD_W-1:0] evt_word(input logic hit, input logic [15:0] line);
    return hit ? {EVT_KIND_HW, line} : '0;
  endfunction

  // Bank index from a byte address.
  function automatic logic [BANK_FW-1:0] addr_bank(input logic [9:0] a);
    return a[7:2];
  endfunction

  // Register group from a byte address.
  function automatic reg_grp_e addr_grp(input logic [9:0] a);
    return reg_grp_e'(a[9:8]);
  endfunction

endpackage

// File: rtl/irq_line_state.sv
module irq_line_state import irq_ctrl_pkg::*; #(
  parameter int NUM_LINES = 64,
  localparam int IDX_W = $clog2(NUM_LINES)
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 wr_en,
  input  reg_grp_e             wr_grp,
  input  logic [BANK_FW-1:0]   wr_bank,
  input  logic [WORD_W-1:0]    wr_data,
  input  logic                 auto_set,
  input  logic [IDX_W-1:0]     auto_idx,
  output logic [NUM_LINES-1:0] mask_q,
  output logic [NUM_LINES-1:0] trig_q
);

  for (genvar i = 0; i < NUM_LINES; i++) begin : g_line
    localparam int BANK = i / WORD_W;
    localparam int BIT  = i % WORD_W;

    logic sel;
    logic auto_hit;
    logic m_r;
    logic t_r;

    assign sel      = wr_en && (wr_bank == BANK_FW'(BANK)) && wr_data[BIT];
    assign auto_hit = auto_set && (auto_idx == IDX_W'(i));

    // The automatic mask from an event read beats a same-edge clear.
    always_ff @(posedge clk) begin
      if (!rst_n)                            m_r <= 1'b1;
      else if (auto_hit)                     m_r <= 1'b1;
      else if (sel && wr_grp == GRP_MASK_SET) m_r <= 1'b1;
      else if (sel && wr_grp == GRP_MASK_CLR) m_r <= 1'b0;
    end

    always_ff @(posedge clk) begin
      if (!rst_n)                            t_r <= 1'b0;
      else if (sel && wr_grp == GRP_TRIG_SET) t_r <= 1'b1;
      else if (sel && wr_grp == GRP_TRIG_CLR) t_r <= 1'b0;
    end

    assign mask_q[i] = m_r;
    assign trig_q[i] = t_r;
  end

endmodule

// File: rtl/irq_prio_pick.sv
module irq_prio_pick #(
  parameter int NUM_LINES = 64,
  localparam int IDX_W = $clog2(NUM_LINES)
) (
  input  logic [NUM_LINES-1:0] active,
  output logic                 any,
  output logic [IDX_W-1:0]     idx
);

  // Scan from the top so the lowest set index is the last to land.
  always_comb begin
    idx = '0;
    for (int i = NUM_LINES - 1; i >= 0; i--) begin
      if (active[i]) idx = IDX_W'(i);
    end
  end

  assign any = |active;

endmodule

// File: rtl/irq_bus_port.sv
module irq_bus_port import irq_ctrl_pkg::*; #(
  parameter int NUM_LINES = 64,
  parameter int ADDR_W = 10,
  localparam int NBANK = (NUM_LINES + WORD_W - 1) / WORD_W,
  localparam int PADW = NBANK * WORD_W
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 bus_req,
  input  logic                 bus_we,
  input  logic [ADDR_W-1:0]    bus_addr,
  input  logic [WORD_W-1:0]    bus_wdata,
  input  logic [NUM_LINES-1:0] mask_q,
  input  logic [NUM_LINES-1:0] trig_q,
  output logic                 wr_en,
  output reg_grp_e             wr_grp,
  output logic [BANK_FW-1:0]   wr_bank,
  output logic [WORD_W-1:0]    wr_data,
  output logic [WORD_W-1:0]    bus_rdata,
  output logic                 bus_rvalid
);

  logic                addr_ok;
  logic                rd_en;
  logic [PADW-1:0]     mask_pad;
  logic [PADW-1:0]     trig_pad;
  logic [WORD_W-1:0]   rd_word;

  assign wr_grp   = addr_grp(bus_addr[9:0]);
  assign wr_bank  = addr_bank(bus_addr[9:0]);
  assign wr_data  = bus_wdata;
  assign addr_ok  = (bus_addr[1:0] == 2'b00) && (int'(wr_bank) < NBANK);
  assign wr_en    = bus_req && bus_we && addr_ok;
  assign rd_en    = bus_req && !bus_we;

  assign mask_pad = PADW'(mask_q);
  assign trig_pad = PADW'(trig_q);

  always_comb begin
    rd_word = '0;
    if (addr_ok) begin
      if (wr_grp == GRP_TRIG_SET || wr_grp == GRP_TRIG_CLR)
        rd_word = trig_pad[int'(wr_bank) * WORD_W +: WORD_W];
      else
        rd_word = mask_pad[int'(wr_bank) * WORD_W +: WORD_W];
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      bus_rvalid <= 1'b0;
      bus_rdata  <= '0;
    end else begin
      bus_rvalid <= rd_en;
      bus_rdata  <= rd_en ? rd_word : '0;
    end
  end

endmodule

// File: rtl/irq_event_port.sv
module irq_event_port import irq_ctrl_pkg::*; #(
  parameter int NUM_LINES = 64,
  localparam int IDX_W = $clog2(NUM_LINES)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              evt_rd,
  input  logic              win_any,
  input  logic [IDX_W-1:0]  win_idx,
  output logic              auto_set,
  output logic [WORD_W-1:0] evt_rdata,
  output logic              evt_rvalid
);

  assign auto_set = evt_rd && win_any;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      evt_rvalid <= 1'b0;
      evt_rdata  <= '0;
    end else begin
      evt_rvalid <= evt_rd;
      evt_rdata  <= evt_rd ? evt_word(win_any, 16'(win_idx)) : '0;
    end
  end

endmodule

// File: rtl/irq_prio_ctrl.sv
module irq_prio_ctrl import irq_ctrl_pkg::*; #(
  parameter int NUM_LINES = 64,
  parameter int ADDR_W = 10,
  localparam int IDX_W = $clog2(NUM_LINES)
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic [NUM_LINES-1:0] hw_irq,
  input  logic                 bus_req,
  input  logic                 bus_we,
  input  logic [ADDR_W-1:0]    bus_addr,
  input  logic [31:0]          bus_wdata,
  output logic [31:0]          bus_rdata,
  output logic                 bus_rvalid,
  input  logic                 evt_rd,
  output logic [31:0]          evt_rdata,
  output logic                 evt_rvalid,
  output logic                 irq_out
);

  logic                 wr_en;
  reg_grp_e             wr_grp;
  logic [BANK_FW-1:0]   wr_bank;
  logic [WORD_W-1:0]    wr_data;
  logic [NUM_LINES-1:0] mask_q;
  logic [NUM_LINES-1:0] trig_q;
  logic [NUM_LINES-1:0] active_vec;
  logic                 win_any;
  logic [IDX_W-1:0]     win_idx;
  logic                 auto_set;

  irq_bus_port #(.NUM_LINES(NUM_LINES), .ADDR_W(ADDR_W)) u_bus (
    .clk(clk), .rst_n(rst_n),
    .bus_req(bus_req), .bus_we(bus_we), .bus_addr(bus_addr), .bus_wdata(bus_wdata),
    .mask_q(mask_q), .trig_q(trig_q),
    .wr_en(wr_en), .wr_grp(wr_grp), .wr_bank(wr_bank), .wr_data(wr_data),
    .bus_rdata(bus_rdata), .bus_rvalid(bus_rvalid)
  );

  irq_line_state #(.NUM_LINES(NUM_LINES)) u_state (
    .clk(clk), .rst_n(rst_n),
    .wr_en(wr_en), .wr_grp(wr_grp), .wr_bank(wr_bank), .wr_data(wr_data),
    .auto_set(auto_set), .auto_idx(win_idx),
    .mask_q(mask_q), .trig_q(trig_q)
  );

  assign active_vec = (hw_irq | trig_q) & ~mask_q;

  irq_prio_pick #(.NUM_LINES(NUM_LINES)) u_pick (
    .active(active_vec), .any(win_any), .idx(win_idx)
  );

  irq_event_port #(.NUM_LINES(NUM_LINES)) u_evt (
    .clk(clk), .rst_n(rst_n),
    .evt_rd(evt_rd), .win_any(win_any), .win_idx(win_idx),
    .auto_set(auto_set), .evt_rdata(evt_rdata), .evt_rvalid(evt_rvalid)
  );

  assign irq_out = win_any;

endmodule

// File: rtl/irq_prio_ctrl_chk.sv
module irq_prio_ctrl_chk #(
  parameter int NUM_LINES = 64,
  localparam int IDX_W = $clog2(NUM_LINES)
) (
  input logic                 clk,
  input logic                 rst_n,
  input logic                 bus_req,
  input logic                 bus_we,
  input logic                 bus_rvalid,
  input logic                 evt_rd,
  input logic                 evt_rvalid,
  input logic [31:0]          evt_rdata,
  input logic [NUM_LINES-1:0] mask_q,
  input logic [NUM_LINES-1:0] active_vec,
  input logic                 win_any,
  input logic [IDX_W-1:0]     win_idx,
  input logic                 irq_out
);

  logic [NUM_LINES-1:0] prev_active;
  logic [IDX_W-1:0]     rep_idx;
  logic [NUM_LINES-1:0] below_rep;

  always_ff @(posedge clk) begin
    if (!rst_n) prev_active <= '0;
    else        prev_active <= active_vec;
  end

  assign rep_idx   = evt_rdata[IDX_W-1:0];
  assign below_rep = (NUM_LINES'(1) << rep_idx) - NUM_LINES'(1);

  // R10: read data arrives one cycle after the request
  p_bus_lat_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_req && !bus_we) |=> bus_rvalid);
  p_evt_lat_r10: assert property (@(posedge clk) disable iff (!rst_n)
    evt_rd |=> evt_rvalid);

  // R2: with every line masked the CPU output stays low
  p_masked_quiet_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (&mask_q) |-> !irq_out);

  // R5: reported line was active and nothing lower was
  p_lowest_wins_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (evt_rvalid && evt_rdata[31:16] == 16'h0001)
      |-> (prev_active[rep_idx] && ((prev_active & below_rep) == '0)));

  // R6, R8: the reported line is masked after the read, whatever the bus did
  p_auto_mask_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (evt_rd && win_any) |=> mask_q[$past(win_idx)]);

  // R7: empty read returns zero and leaves masks alone
  p_empty_read_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (evt_rd && !win_any && !(bus_req && bus_we)) |=> (evt_rdata == 32'h0 && $stable(mask_q)));

endmodule

bind irq_prio_ctrl irq_prio_ctrl_chk #(.NUM_LINES(NUM_LINES)) u_chk (
  .clk(clk), .rst_n(rst_n), .bus_req(bus_req), .bus_we(bus_we),
  .bus_rvalid(bus_rvalid), .evt_rd(evt_rd), .evt_rvalid(evt_rvalid),
  .evt_rdata(evt_rdata), .mask_q(mask_q), .active_vec(active_vec),
  .win_any(win_any), .win_idx(win_idx), .irq_out(irq_out)
);

// File: tb/test_irq_prio_ctrl.sv
`timescale 1ns/1ps
module test_irq_prio_ctrl;

  localparam int N = 64;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic [N-1:0]  hw_irq = '0;
  logic          bus_req = 1'b0;
  logic          bus_we = 1'b0;
  logic [9:0]    bus_addr = '0;
  logic [31:0]   bus_wdata = '0;
  logic [31:0]   bus_rdata;
  logic          bus_rvalid;
  logic          evt_rd = 1'b0;
  logic [31:0]   evt_rdata;
  logic          evt_rvalid;
  logic          irq_out;

  int vecs = 0;
  int miss = 0;
  bit done = 0;

  logic [N-1:0] m_mask = '1;
  logic [N-1:0] m_sw = '0;

  logic [31:0] bus_q[$];
  string       bus_t[$];
  logic [31:0] evt_q[$];
  string       evt_t[$];

  always #2 clk = ~clk;

  irq_prio_ctrl #(.NUM_LINES(N), .ADDR_W(10)) i_irq_prio_ctrl (
    .clk(clk), .rst_n(rst_n), .hw_irq(hw_irq),
    .bus_req(bus_req), .bus_we(bus_we), .bus_addr(bus_addr), .bus_wdata(bus_wdata),
    .bus_rdata(bus_rdata), .bus_rvalid(bus_rvalid),
    .evt_rd(evt_rd), .evt_rdata(evt_rdata), .evt_rvalid(evt_rvalid),
    .irq_out(irq_out)
  );

  task automatic chk(string tg, logic [31:0] got, logic [31:0] exp);
    vecs++;
    if (got !== exp) begin
      miss++;
      $display("FAIL %s got %h expected %h", tg, got, exp);
    end
  endtask

  function automatic logic [9:0] ra(int grp, int bank);
    return {grp[1:0], bank[5:0], 2'b00};
  endfunction

  function automatic void model_write(int grp, int bank, logic [31:0] d);
    for (int k = 0; k < 32; k++) begin
      int ln = bank * 32 + k;
      if (ln < N && d[k]) begin
        case (grp)
          0: m_mask[ln] = 1'b1;
          1: m_mask[ln] = 1'b0;
          2: m_sw[ln] = 1'b1;
          default: m_sw[ln] = 1'b0;
        endcase
      end
    end
  endfunction

  // Monitor: compares results in the cycle they are due.
  always @(negedge clk) begin
    if (rst_n && bus_rvalid) begin
      if (bus_q.size() == 0) chk("R10 unexpected bus_rvalid", 32'd1, 32'd0);
      else chk(bus_t.pop_front(), bus_rdata, bus_q.pop_front());
    end
    if (rst_n && evt_rvalid) begin
      if (evt_q.size() == 0) chk("R10 unexpected evt_rvalid", 32'd1, 32'd0);
      else chk(evt_t.pop_front(), evt_rdata, evt_q.pop_front());
    end
  end

  task automatic drained(string tg);
    chk({tg, " R10 response late or missing"}, 32'(bus_q.size() + evt_q.size()), 32'd0);
  endtask

  task automatic bus_write(int grp, int bank, logic [31:0] d);
    bus_req = 1; bus_we = 1; bus_addr = ra(grp, bank); bus_wdata = d;
    @(negedge clk);
    bus_req = 0; bus_we = 0;
    void'(model_write(grp, bank, d));
    @(negedge clk);
  endtask

  task automatic bus_read(int grp, int bank, string tg);
    logic [31:0] e;
    for (int k = 0; k < 32; k++)
      e[k] = (grp >= 2) ? m_sw[bank * 32 + k] : m_mask[bank * 32 + k];
    bus_q.push_back(e); bus_t.push_back(tg);
    bus_req = 1; bus_we = 0; bus_addr = ra(grp, bank);
    @(negedge clk);
    bus_req = 0;
    @(negedge clk);
    drained(tg);
  endtask

  task automatic evt_read(string tg, bit with_clr, int cbank, logic [31:0] cdata);
    logic [N-1:0] act;
    int  win;
    act = (hw_irq | m_sw) & ~m_mask;
    win = -1;
    for (int i = N - 1; i >= 0; i--) if (act[i]) win = i;
    evt_q.push_back(win >= 0 ? {16'h0001, 16'(win)} : 32'h0);
    evt_t.push_back(tg);
    evt_rd = 1;
    if (with_clr) begin
      bus_req = 1; bus_we = 1; bus_addr = ra(1, cbank); bus_wdata = cdata;
    end
    @(negedge clk);
    evt_rd = 0; bus_req = 0; bus_we = 0;
    if (with_clr) void'(model_write(1, cbank, cdata));
    if (win >= 0) m_mask[win] = 1'b1;
    @(negedge clk);
    drained(tg);
  endtask

  task automatic chk_irq(string tg);
    chk(tg, 32'(irq_out), 32'(|((hw_irq | m_sw) & ~m_mask)));
  endtask

  initial begin
    #200000;
    if (!done) begin
      miss++; vecs++;
      $display("FAIL watchdog expired");
      $display("== %0d vectors applied, %0d miscompares ==", vecs, miss);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    chk("R1 irq_out in reset", 32'(irq_out), 32'd0);
    rst_n = 1;
    @(negedge clk);
    chk("R1 bus_rvalid after reset", 32'(bus_rvalid), 32'd0);
    chk("R1 evt_rvalid after reset", 32'(evt_rvalid), 32'd0);
    bus_read(0, 0, "R1 mask bank0 after reset");
    bus_read(1, 1, "R1 mask bank1 after reset");
    bus_read(2, 0, "R1 trig bank0 after reset");

    // R2: masked hw line does not reach the output
    hw_irq[5] = 1'b1;
    @(negedge clk);
    chk_irq("R2 masked line quiet");
    bus_write(1, 0, 32'h0000_0020);
    chk_irq("R2 unmasked line raises irq");
    bus_read(1, 0, "R3 mask clear readback");

    // R5/R6: single line reported and auto-masked
    evt_read("R5 single line event", 0, 0, 0);
    chk_irq("R6 irq drops after event read");
    bus_read(0, 0, "R6 mask set by event read");

    // R7: empty read
    evt_read("R7 empty event read", 0, 0, 0);
    bus_read(0, 0, "R7 masks unchanged");
    bus_read(0, 1, "R7 masks bank1 unchanged");

    // R5 priority order over hw and sw sources, R4 triggers
    hw_irq[7] = 1'b1; hw_irq[40] = 1'b1;
    bus_write(2, 1, 32'h8000_0000);
    bus_read(3, 1, "R4 trig set readback");
    bus_write(1, 0, 32'hFFFF_FFFF);
    bus_write(1, 1, 32'hFFFF_FFFF);
    chk_irq("R2 sw and hw requests");
    evt_read("R5 order first", 0, 0, 0);
    evt_read("R5 order second", 0, 0, 0);
    evt_read("R5 order third", 0, 0, 0);
    evt_read("R5 sw line last", 0, 0, 0);
    chk_irq("R6 all reported lines masked");
    evt_read("R7 empty after drain", 0, 0, 0);
    bus_write(3, 1, 32'h8000_0000);
    bus_read(2, 1, "R4 trig clear readback");

    // R9: level line still high fires again after unmask
    bus_write(1, 0, 32'h0000_0020);
    chk_irq("R9 level line requests again");
    evt_read("R9 level line reported again", 0, 0, 0);

    // R8: auto-mask beats simultaneous clear
    bus_write(1, 0, 32'h0000_0080);
    evt_read("R8 event with same-edge clear", 1, 0, 32'h0000_0080);
    bus_read(0, 0, "R8 line stays masked");
    chk_irq("R8 irq after collision");

    // R2: software trigger alone, R3 set path
    bus_write(2, 0, 32'h0000_0400);
    chk_irq("R2 sw trigger masked");
    bus_write(1, 0, 32'h0000_0400);
    chk_irq("R2 sw trigger unmasked");
    bus_write(0, 0, 32'h0000_0400);
    chk_irq("R3 mask set silences line");
    bus_read(0, 0, "R3 mask set readback");
    bus_write(1, 0, 32'h0000_0400);
    evt_read("R5 sw-only line event", 0, 0, 0);

    // R9: hw drop then rise while unmasked
    hw_irq[40] = 1'b0;
    bus_write(1, 1, 32'h0000_0100);
    chk_irq("R9 low line quiet");
    hw_irq[40] = 1'b1;
    @(negedge clk);
    chk_irq("R9 line rises");
    evt_read("R9 line 40 reported", 0, 0, 0);

    repeat (2) @(negedge clk);
    done = 1;
    $display("== %0d vectors applied, %0d miscompares ==", vecs, miss);
    $finish;
  end

endmodule